// File: doc/BRIEF.md
# Carry-Chain Integer Adder Unit

This unit is the add/subtract slice of a 32-bit fixed-point execution stage. Each cycle with a valid strobe it takes two register operands that have already been read, a 16-bit immediate, the index of the first source register and a four-bit operation code. From these it forms one three-input sum: a first addend (the A operand, its inverse, or literal zero), a second addend (B, the sign-extended immediate, the immediate moved into the upper half, all ones, or zero) and a carry-in (zero, one, or the unit's own carry flag). The sum is written to a result register one clock later.

The unit keeps two pieces of state. The first is a carry flag that many operations update from the carry out of the top bit. The second is a four-bit condition field that sorts the result into negative, positive or zero and also copies the sticky summary-overflow bit supplied by the surrounding stage. Subtraction is always done by inverting A and forcing or taking a carry-in, so a single adder serves every operation. The extended forms read the carry flag that the previous valid operation left, which lets the stage chain multi-word arithmetic at one operation per cycle.

Top module: `carry_adder_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `result`, `res_valid`, `carry` and `cond` to zero at the next clock edge.
- R2: Op code 0 (immediate add) yields A + sign-extended immediate. When `a_idx` is zero, A is replaced by literal zero. Carry and cond are unchanged.
- R3: Op code 1 (upper-immediate add) yields A + (immediate placed in bits 31..16 with zeros below), with the same zero rule for `a_idx` == 0. Carry and cond are unchanged.
- R4: Op codes 2 and 3 yield A + sign-extended immediate, ignoring `a_idx`. Both update carry. Code 3 also updates cond.
- R5: Op code 4 (reverse subtract from immediate) yields NOT A + sign-extended immediate + 1 and updates carry.
- R6: Op code 5 (negate) yields NOT A + 1 and leaves carry unchanged.
- R7: Op code 6 yields A + B + carry flag. Op code 7 yields NOT A + B + carry flag. Both update carry.
- R8: Op code 8 yields A + all-ones + carry flag. Op code 9 yields NOT A + all-ones + carry flag. Op code 10 yields A + carry flag. All three update carry.
- R9: When an operation updates carry, the new flag is bit 32 of the unsigned 33-bit sum of its three addends. Codes 0, 1, 5 and 11..15 leave the flag unchanged.
- R10: On an update, `cond` is {LT, GT, EQ, SO} in bits 3..0. LT is result bit 31. EQ is set when the result is zero. GT is set when neither LT nor EQ is set. SO copies `so_in` from that cycle.
- R11: Code 3 always updates `cond`. Codes 5..10 update `cond` only when `cc_req` is 1. For every other code, `cc_req` is ignored and `cond` is unchanged.
- R12: `res_valid` is `in_valid` delayed by one cycle. `result`, `carry` and `cond` change only at an edge where `in_valid` is 1 and hold otherwise.
- R13: Op codes 11..15 produce a result of zero and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (0..10 defined) |
| a_idx | input | 5 | Index of the first source register, used for the zero rule |
| a_val | input | 32 | First register operand |
| b_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| cc_req | input | 1 | Request a cond update for register forms |
| so_in | input | 1 | Current sticky summary-overflow bit |
| res_valid | output | 1 | Result register holds a new value |
| result | output | 32 | Registered sum |
| carry | output | 1 | Carry flag |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
In a single cycle, an extended operation both consumes the carry flag as its carry-in and writes a new carry flag that the very next operation reads. The bench provokes this by issuing operations back to back with no idle cycle across a sweep of every op code and corner operands, so the carry-in is whatever the previous operation left. The cond update that code 3 or `cc_req` asks for lands in the same cycle as the carry update, and both flags are judged against a bench model after every edge. Idle cycles with changed inputs are mixed into the stream to show that neither flag nor the result moves without a strobe.

// File: rtl/adu_pkg.sv
package adu_pkg;

   localparam int COND_W  = 4;
   localparam int COND_LT = 3;
   localparam int COND_GT = 2;
   localparam int COND_EQ = 1;
   localparam int COND_SO = 0;
   localparam int OP_W    = 4;

   localparam logic [OP_W-1:0] OP_ADD_IMM    = 4'd0;
   localparam logic [OP_W-1:0] OP_ADD_IMM_HI = 4'd1;
   localparam logic [OP_W-1:0] OP_ADD_IMM_CA = 4'd2;
   localparam logic [OP_W-1:0] OP_ADD_IMM_CC = 4'd3;
   localparam logic [OP_W-1:0] OP_RSUB_IMM   = 4'd4;
   localparam logic [OP_W-1:0] OP_NEG        = 4'd5;
   localparam logic [OP_W-1:0] OP_ADD_EXT    = 4'd6;
   localparam logic [OP_W-1:0] OP_SUB_EXT    = 4'd7;
   localparam logic [OP_W-1:0] OP_ADD_M1_EXT = 4'd8;
   localparam logic [OP_W-1:0] OP_SUB_M1_EXT = 4'd9;
   localparam logic [OP_W-1:0] OP_ADD_Z_EXT  = 4'd10;

   typedef enum logic [1:0] {
      ASRC_REG,
      ASRC_ZERO,
      ASRC_INV
   } a_src_e;

   typedef enum logic [2:0] {
      BSRC_ZERO,
      BSRC_REG,
      BSRC_SIMM,
      BSRC_HIMM,
      BSRC_ONES
   } b_src_e;

   typedef enum logic [1:0] {
      CIN_ZERO,
      CIN_ONE,
      CIN_FLAG
   } cin_e;

   typedef struct packed {
      a_src_e a_src;
      b_src_e b_src;
      cin_e   cin;
      logic   upd_ca;
      logic   cc_always;
      logic   cc_allowed;
   } adu_ctrl_t;

endpackage

// File: rtl/adu_decode.sv
module adu_decode
   import adu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   input  logic            a_idx_zero,
   output adu_ctrl_t       ctrl
);

   always_comb begin
      ctrl.a_src      = ASRC_ZERO;
      ctrl.b_src      = BSRC_ZERO;
      ctrl.cin        = CIN_ZERO;
      ctrl.upd_ca     = 1'b0;
      ctrl.cc_always  = 1'b0;
      ctrl.cc_allowed = 1'b0;
      case (op)
         OP_ADD_IMM: begin
            ctrl.a_src = a_idx_zero ? ASRC_ZERO : ASRC_REG;
            ctrl.b_src = BSRC_SIMM;
         end
         OP_ADD_IMM_HI: begin
            ctrl.a_src = a_idx_zero ? ASRC_ZERO : ASRC_REG;
            ctrl.b_src = BSRC_HIMM;
         end
         OP_ADD_IMM_CA: begin
            ctrl.a_src  = ASRC_REG;
            ctrl.b_src  = BSRC_SIMM;
            ctrl.upd_ca = 1'b1;
         end
         OP_ADD_IMM_CC: begin
            ctrl.a_src     = ASRC_REG;
            ctrl.b_src     = BSRC_SIMM;
            ctrl.upd_ca    = 1'b1;
            ctrl.cc_always = 1'b1;
         end
         OP_RSUB_IMM: begin
            ctrl.a_src  = ASRC_INV;
            ctrl.b_src  = BSRC_SIMM;
            ctrl.cin    = CIN_ONE;
            ctrl.upd_ca = 1'b1;
         end
         OP_NEG: begin
            ctrl.a_src      = ASRC_INV;
            ctrl.b_src      = BSRC_ZERO;
            ctrl.cin        = CIN_ONE;
            ctrl.cc_allowed = 1'b1;
         end
         OP_ADD_EXT: begin
            ctrl.a_src      = ASRC_REG;
            ctrl.b_src      = BSRC_REG;
            ctrl.cin        = CIN_FLAG;
            ctrl.upd_ca     = 1'b1;
            ctrl.cc_allowed = 1'b1;
         end
         OP_SUB_EXT: begin
            ctrl.a_src      = ASRC_INV;
            ctrl.b_src      = BSRC_REG;
            ctrl.cin        = CIN_FLAG;
            ctrl.upd_ca     = 1'b1;
            ctrl.cc_allowed = 1'b1;
         end
         OP_ADD_M1_EXT: begin
            ctrl.a_src      = ASRC_REG;
            ctrl.b_src      = BSRC_ONES;
            ctrl.cin        = CIN_FLAG;
            ctrl.upd_ca     = 1'b1;
            ctrl.cc_allowed = 1'b1;
         end
         OP_SUB_M1_EXT: begin
            ctrl.a_src      = ASRC_INV;
            ctrl.b_src      = BSRC_ONES;
            ctrl.cin        = CIN_FLAG;
            ctrl.upd_ca     = 1'b1;
            ctrl.cc_allowed = 1'b1;
         end
         OP_ADD_Z_EXT: begin
            ctrl.a_src      = ASRC_REG;
            ctrl.b_src      = BSRC_ZERO;
            ctrl.cin        = CIN_FLAG;
            ctrl.upd_ca     = 1'b1;
            ctrl.cc_allowed = 1'b1;
         end
         default: begin
            ctrl.a_src = ASRC_ZERO;
         end
      endcase
   end

endmodule

// File: rtl/adu_operands.sv
module adu_operands
   import adu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  adu_ctrl_t         ctrl,
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] b_val,
   input  logic [IMM_W-1:0]  imm,
   input  logic              carry_flag,
   output logic [DATA_W-1:0] opa,
   output logic [DATA_W-1:0] opb,
   output logic              cin
);

   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] simm;
   logic [DATA_W-1:0] himm;

   assign simm = {{PAD_W{imm[IMM_W-1]}}, imm};
   assign himm = {imm, {PAD_W{1'b0}}};

   always_comb begin
      case (ctrl.a_src)
         ASRC_REG: opa = a_val;
         ASRC_INV: opa = ~a_val;
         default:  opa = '0;
      endcase
   end

   always_comb begin
      case (ctrl.b_src)
         BSRC_REG:  opb = b_val;
         BSRC_SIMM: opb = simm;
         BSRC_HIMM: opb = himm;
         BSRC_ONES: opb = '1;
         default:   opb = '0;
      endcase
   end

   always_comb begin
      case (ctrl.cin)
         CIN_ONE:  cin = 1'b1;
         CIN_FLAG: cin = carry_flag;
         default:  cin = 1'b0;
      endcase
   end

endmodule

// File: rtl/adu_sum.sv
module adu_sum #(
   parameter int DATA_W       = 32,
   parameter bit RIPPLE_CARRY = 1'b0
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);

   generate
      if (RIPPLE_CARRY) begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic prop;
            assign prop         = opa[i] ^ opb[i];
            assign sum[i]       = prop ^ chain[i];
            assign chain[i+1]   = (opa[i] & opb[i]) | (prop & chain[i]);
         end
         assign cout = chain[DATA_W];
      end else begin : g_infer
         logic [DATA_W:0] wide;
         assign wide = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
         assign sum  = wide[DATA_W-1:0];
         assign cout = wide[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/adu_cond.sv
module adu_cond
   import adu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] value,
   input  logic              so_in,
   output logic [COND_W-1:0] cond_next
);

   logic is_zero;
   logic is_neg;

   assign is_zero = (value == '0);
   assign is_neg  = value[DATA_W-1];

   always_comb begin
      cond_next          = '0;
      cond_next[COND_LT] = is_neg;
      cond_next[COND_EQ] = is_zero;
      cond_next[COND_GT] = !is_neg && !is_zero;
      cond_next[COND_SO] = so_in;
   end

endmodule

// File: rtl/carry_adder_unit.sv
module carry_adder_unit
   import adu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter int IDX_W        = 5,
   parameter bit RIPPLE_CARRY = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] b_val,
   input  logic [IMM_W-1:0]  imm,
   input  logic              cc_req,
   input  logic              so_in,
   output logic              res_valid,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic [3:0]        cond
);

   generate
      if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("carry_adder_unit: IMM_W must lie in 1..DATA_W-1");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("carry_adder_unit: IDX_W must be at least 1");
      end
      if (COND_W != 4) begin : g_bad_cond
         $error("carry_adder_unit: condition field must be four bits");
      end
   endgenerate

   adu_ctrl_t         ctrl;
   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   logic              cin;
   logic [DATA_W-1:0] sum;
   logic              cout;
   logic [COND_W-1:0] cond_next;
   logic              a_idx_zero;
   logic              upd_cc;

   logic              valid_q;
   logic [DATA_W-1:0] result_q;
   logic              carry_q;
   logic [COND_W-1:0] cond_q;

   assign a_idx_zero = (a_idx == '0);

   adu_decode u_decode (
      .op         (op),
      .a_idx_zero (a_idx_zero),
      .ctrl       (ctrl)
   );

   adu_operands #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_operands (
      .ctrl       (ctrl),
      .a_val      (a_val),
      .b_val      (b_val),
      .imm        (imm),
      .carry_flag (carry_q),
      .opa        (opa),
      .opb        (opb),
      .cin        (cin)
   );

   adu_sum #(
      .DATA_W       (DATA_W),
      .RIPPLE_CARRY (RIPPLE_CARRY)
   ) u_sum (
      .opa  (opa),
      .opb  (opb),
      .cin  (cin),
      .sum  (sum),
      .cout (cout)
   );

   adu_cond #(
      .DATA_W (DATA_W)
   ) u_cond (
      .value     (sum),
      .so_in     (so_in),
      .cond_next (cond_next)
   );

   assign upd_cc = ctrl.cc_always | (ctrl.cc_allowed & cc_req);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q  <= 1'b0;
         result_q <= '0;
         carry_q  <= 1'b0;
         cond_q   <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            result_q <= sum;
            if (ctrl.upd_ca) begin
               carry_q <= cout;
            end
            if (upd_cc) begin
               cond_q <= cond_next;
            end
         end
      end
   end

   assign res_valid = valid_q;
   assign result    = result_q;
   assign carry     = carry_q;
   assign cond      = cond_q;

endmodule

// File: rtl/carry_adder_unit_chk.sv
module carry_adder_unit_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [3:0]        op,
   input logic [IDX_W-1:0]  a_idx,
   input logic [DATA_W-1:0] a_val,
   input logic [IMM_W-1:0]  imm,
   input logic              cc_req,
   input logic              so_in,
   input logic              res_valid,
   input logic [DATA_W-1:0] result,
   input logic              carry,
   input logic [3:0]        cond
);

   function automatic logic [DATA_W-1:0] sx(input logic [IMM_W-1:0] v);
      return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
   endfunction

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!res_valid && result == '0 && !carry && cond == 4'd0));

   assert_zero_index_imm_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 4'd0 && a_idx == '0) |=> (result == sx($past(imm))));

   assert_negate_result_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 4'd5) |=> (result == (~$past(a_val) + 1'b1)));

   assert_carry_kept_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (op == 4'd0 || op == 4'd1 || op == 4'd5 || op > 4'd10)) |=> $stable(carry));

   assert_cond_class_R10: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 4'd3) |=> (cond[1] == (result == '0) && cond[3] == result[DATA_W-1]
                                     && cond[0] == $past(so_in)));

   assert_cond_onehot_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cond[3:1]));

   assert_cond_ignored_R11: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !cc_req && op != 4'd3) |=> $stable(cond));

   assert_valid_delay_R12: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!res_valid && $stable(result) && $stable(carry) && $stable(cond)));

endmodule

bind carry_adder_unit carry_adder_unit_chk #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op        (op),
   .a_idx     (a_idx),
   .a_val     (a_val),
   .imm       (imm),
   .cc_req    (cc_req),
   .so_in     (so_in),
   .res_valid (res_valid),
   .result    (result),
   .carry     (carry),
   .cond      (cond)
);

// File: tb/carry_adder_unit_tb.sv
`timescale 1ns/1ps
module carry_adder_unit_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [4:0]  a_idx = '0;
   logic [31:0] a_val = '0;
   logic [31:0] b_val = '0;
   logic [15:0] imm = '0;
   logic        cc_req = 1'b0;
   logic        so_in = 1'b0;
   logic        res_valid;
   logic [31:0] result;
   logic        carry;
   logic [3:0]  cond;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_res = '0;
   logic        m_ca  = 1'b0;
   logic [3:0]  m_cc  = '0;

   always #2.5 clk = ~clk;

   carry_adder_unit u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .op        (op),
      .a_idx     (a_idx),
      .a_val     (a_val),
      .b_val     (b_val),
      .imm       (imm),
      .cc_req    (cc_req),
      .so_in     (so_in),
      .res_valid (res_valid),
      .result    (result),
      .carry     (carry),
      .cond      (cond)
   );

   function automatic string op_tag(input logic [3:0] o);
      case (o)
         4'd0:                 return "R2";
         4'd1:                 return "R3";
         4'd2, 4'd3:           return "R4";
         4'd4:                 return "R5";
         4'd5:                 return "R6";
         4'd6, 4'd7:           return "R7";
         4'd8, 4'd9, 4'd10:    return "R8";
         default:              return "R13";
      endcase
   endfunction

   function automatic logic [31:0] pick_a(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'hFFFF_FFFF;
         default: return 32'h1234_8765;
      endcase
   endfunction

   function automatic logic [15:0] pick_imm(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h7FFF;
         3: return 16'h8000;
         default: return 16'hFFFF;
      endcase
   endfunction

   task automatic check1(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Drive one cycle (called at a negedge), then check after the next edge.
   task automatic step(input logic v, input logic [3:0] o, input logic [4:0] idx,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                       input logic ccr, input logic so);
      logic [31:0] ea, eb, simm;
      logic        ci, uca, ucc;
      logic [32:0] s;
      logic [3:0]  ncc;
      in_valid = v; op = o; a_idx = idx; a_val = a; b_val = b;
      imm = im; cc_req = ccr; so_in = so;
      simm = {{16{im[15]}}, im};
      ea = '0; eb = '0; ci = 1'b0; uca = 1'b0; ucc = 1'b0;
      case (o)
         4'd0: begin ea = (idx == 0) ? 32'd0 : a; eb = simm; end
         4'd1: begin ea = (idx == 0) ? 32'd0 : a; eb = {im, 16'h0}; end
         4'd2: begin ea = a; eb = simm; uca = 1; end
         4'd3: begin ea = a; eb = simm; uca = 1; ucc = 1; end
         4'd4: begin ea = ~a; eb = simm; ci = 1; uca = 1; end
         4'd5: begin ea = ~a; ci = 1; ucc = ccr; end
         4'd6: begin ea = a; eb = b; ci = m_ca; uca = 1; ucc = ccr; end
         4'd7: begin ea = ~a; eb = b; ci = m_ca; uca = 1; ucc = ccr; end
         4'd8: begin ea = a; eb = 32'hFFFF_FFFF; ci = m_ca; uca = 1; ucc = ccr; end
         4'd9: begin ea = ~a; eb = 32'hFFFF_FFFF; ci = m_ca; uca = 1; ucc = ccr; end
         4'd10: begin ea = a; ci = m_ca; uca = 1; ucc = ccr; end
         default: begin end
      endcase
      s = {1'b0, ea} + {1'b0, eb} + {32'd0, ci};
      ncc = {s[31], (!s[31] && s[31:0] != 0), (s[31:0] == 0), so};
      if (v) begin
         m_res = s[31:0];
         if (uca) m_ca = s[32];
         if (ucc) m_cc = ncc;
      end
      @(negedge clk);
      if (v) begin
         check1(op_tag(o), "result", result, m_res);
         check1("R9", "carry", {31'd0, carry}, {31'd0, m_ca});
         check1(ucc ? "R10" : "R11", "cond", {28'd0, cond}, {28'd0, m_cc});
         check1("R12", "res_valid", {31'd0, res_valid}, 32'd1);
      end else begin
         check1("R12", "idle result", result, m_res);
         check1("R12", "idle flags", {27'd0, carry, cond}, {27'd0, m_ca, m_cc});
         check1("R12", "idle res_valid", {31'd0, res_valid}, 32'd0);
      end
   endtask

   task automatic reset_check();
      rst = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      in_valid = 1'b0;
      m_res = '0; m_ca = 1'b0; m_cc = '0;
      check1("R1", "reset result", result, 32'd0);
      check1("R1", "reset flags", {27'd0, carry, cond}, 32'd0);
      check1("R1", "reset res_valid", {31'd0, res_valid}, 32'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      n = 0;
      @(negedge clk);
      @(negedge clk);
      reset_check();
      // Directed: carry chain into extended add, then carry from add-with-carry-immediate
      step(1, 4'd2, 5'd3, 32'hFFFF_FFFF, 32'h0, 16'h0001, 0, 0); // R4 carry out 1
      step(1, 4'd6, 5'd3, 32'h0000_0001, 32'h0000_0002, 16'h0, 1, 1); // R7 uses carry 1
      step(1, 4'd10, 5'd3, 32'hFFFF_FFFF, 32'h0, 16'h0, 1, 0); // R8 zero-extended
      step(1, 4'd1, 5'd0, 32'hDEAD_BEEF, 32'h0, 16'h8001, 1, 0); // R3 zero rule
      step(1, 4'd12, 5'd7, 32'h5555_5555, 32'h1, 16'h7FFF, 1, 1); // R13 unused
      // Sweep every code back to back with corner operands
      for (int o = 0; o < 16; o++) begin
         for (int ia = 0; ia < 6; ia++) begin
            for (int ii = 0; ii < 5; ii++) begin
               for (int k = 0; k < 8; k++) begin
                  logic [31:0] av, bv;
                  av = pick_a(ia);
                  bv = pick_a((ia + ii + k) % 6) ^ {16'h0, pick_imm(ii)};
                  n++;
                  if (n % 7 == 0)
                     step(0, 4'(o + 3), 5'd0, ~av, bv, ~pick_imm(ii), 1, 1);
                  step(1, 4'(o), k[1] ? 5'd0 : 5'd9, av, bv, pick_imm(ii), k[0], k[2]);
               end
            end
         end
      end
      reset_check();
      step(1, 4'd7, 5'd1, 32'h0000_0001, 32'h0000_0001, 16'h0, 1, 0); // R7 after reset, carry 0
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule